// File: doc/BRIEF.md
# Serial Result Output Port

This block keeps the most recent 16-bit conversion word and sends it out one bit at a time on a single data line, `dout`. A chip-select input gates the line. While the select is inactive, `dout_oe` is low so that an outer pad can float the pin. There are two ways to read. In the first, the host holds the select low during a conversion and sees each result bit as soon as the converter resolves it, one per falling edge of the conversion clock. The busy flag marks the start and end of that stream. In the second, the host reads the stored word between conversions with its own serial clock. The most significant bit is already on the line when the select falls, so fifteen serial clock pulses bring out the remaining bits.

All pins are asynchronous to the block clock `clk`. They pass through a common synchronizer chain, so their relative timing is kept. Edges on the serial clock, the conversion clock, the busy flag and the select are detected in the `clk` domain and used as enables. The stored word changes only when a conversion finishes, so a read between conversions always sees one stable word.

Top module: `serial_result_port`

## Requirements
- R1: After reset, `dout_oe` and `dout` are 0 and the stored word is zero. A read taken right after reset therefore returns only zeros.
- R2: `dout_oe` is 1 exactly while the synchronized `cs_n` is low. It follows a change on `cs_n` after SYNC_STAGES+1 `clk` rising edges. While `dout_oe` is 0, `dout` is held at 0.
- R3: When `cs_n` falls and no live bit is pending, the stored word's most significant bit appears on `dout` in the same cycle that `dout_oe` rises. No `sclk` pulse is needed for this.
- R4: Outside a conversion, each high-to-low transition of `sclk` moves `dout` one bit toward the least significant bit. After the 15th such transition, `dout` shows bit 0.
- R5: Every `sclk` falling transition after the one that presented bit 0 puts a 0 on `dout`.
- R6: Each falling edge of `cs_n` restarts the read at the most significant bit of the stored word.
- R7: While `conv_busy` is 1, each falling edge of `cnv_clk` captures `res_bit`. With `cs_n` low, `dout` shows the captured bit from the next output update onward.
- R8: During a conversion, before the first bit is captured, `dout` keeps showing the between-conversion read path. That path still holds the previous word.
- R9: The stored word is replaced only when `conv_busy` falls. The new word is the last 16 bits captured, with the first captured bit placed at bit 15.
- R10: `sclk` transitions while `conv_busy` is 1 do not move the read position.
- R11: When a conversion ends, the read path reloads with the new word. With `cs_n` held low, `dout` then presents the new bit 15 without the select being toggled.
- R12: `cnv_clk` falling edges while `conv_busy` is 0 capture nothing and leave the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Host serial clock for reads between conversions |
| cnv_clk | input | 1 | Conversion clock; one result bit per falling edge |
| conv_busy | input | 1 | High while a conversion is running |
| res_bit | input | 1 | Bit currently resolved by the converter |
| dout | output | 1 | Serial data, most significant bit first |
| dout_oe | output | 1 | Output enable for the tri-state data pad |

## Verification
The bench covers the following corner cases:

- **Zero tail.** It reads past the fifteenth `sclk` pulse. A shifter that wraps around or stops would repeat stale bits instead of zeros.
- **Output without a pulse.** It checks `dout` right after the select falls, before any `sclk` pulse. A design that needs a pulse first would be one bit late for the whole word.
- **Read position during a conversion.** It sends `sclk` pulses while a conversion is running. A design that lets them through would shift the old word out from under the live stream.
- **End of conversion.** It keeps the select low through the end of a conversion. A design that does not reload there leaves the old word's bits on the line.
- **Stray conversion clocks.** It sends `cnv_clk` edges while the block is idle. A design that captures them would corrupt the next stored word.
- **Stored-word timing.** It checks that the old word is still readable during a conversion. A design that updates the stored word early would show the new word too soon.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic cnv;
    logic busy;
    logic bit_in;
  } pin_t;

  localparam int PIN_W = $bits(pin_t);

  localparam pin_t PIN_RST = '{cs_n: 1'b1, sclk: 1'b0, cnv: 1'b0, busy: 1'b0, bit_in: 1'b0};
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/srp_hist.sv
module srp_hist #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= cur;
  end
endmodule

// File: rtl/srp_capture.sv
module srp_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         busy_s,
  input  logic         busy_rise,
  input  logic         busy_fall,
  input  logic         cnv_fall,
  input  logic         bit_s,
  output logic [W-1:0] stored_q,
  output logic [W-1:0] stored_d,
  output logic         live_have_d,
  output logic         live_bit_d
);
  logic [W-1:0] acc_q, acc_d;
  logic         have_q, lbit_q;

  always_comb begin
    acc_d       = acc_q;
    live_have_d = have_q;
    live_bit_d  = lbit_q;
    stored_d    = stored_q;
    if (busy_rise) begin
      acc_d       = '0;
      live_have_d = 1'b0;
    end
    if (busy_s && cnv_fall) begin
      acc_d       = {acc_d[W-2:0], bit_s};
      live_have_d = 1'b1;
      live_bit_d  = bit_s;
    end
    if (busy_fall) begin
      stored_d    = acc_q;
      live_have_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      have_q   <= 1'b0;
      lbit_q   <= 1'b0;
      stored_q <= '0;
    end else begin
      acc_q    <= acc_d;
      have_q   <= live_have_d;
      lbit_q   <= live_bit_d;
      stored_q <= stored_d;
    end
  end
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         adv,
  output logic         head_d
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)     sh_d = load_word;
    else if (adv) sh_d = {sh_q[W-2:0], 1'b0};
  end

  assign head_d = sh_d[W-1];

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= sh_d;
  end
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic cnv_clk,
  input  logic conv_busy,
  input  logic res_bit,
  output logic dout,
  output logic dout_oe
);
  import srp_pkg::*;

  localparam int EDGE_W = 4;
  localparam logic [EDGE_W-1:0] EDGE_RST = PIN_RST[PIN_W-1 -: EDGE_W];

  pin_t              pins_raw, pins_s;
  logic [PIN_W-1:0]  pins_sv;
  logic [EDGE_W-1:0] edge_cur, edge_prev;
  logic cs_s, sclk_s, cnv_s, conv_s, res_s;
  logic cs_fall, sclk_fall, cnv_fall, busy_rise, busy_fall;
  logic [DATA_W-1:0] stored_word, stored_next;
  logic live_have_d, live_bit_d, head_d, out_bit;
  logic dout_q, oe_q;

  assign pins_raw = '{cs_n: cs_n, sclk: sclk, cnv: cnv_clk, busy: conv_busy, bit_in: res_bit};

  srp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk), .rst (rst), .din (pins_raw), .dout (pins_sv)
  );

  assign pins_s = pin_t'(pins_sv);
  assign cs_s   = pins_s.cs_n;
  assign sclk_s = pins_s.sclk;
  assign cnv_s  = pins_s.cnv;
  assign conv_s = pins_s.busy;
  assign res_s  = pins_s.bit_in;

  assign edge_cur = {cs_s, sclk_s, cnv_s, conv_s};

  srp_hist #(.W(EDGE_W), .RST_VAL(EDGE_RST)) u_hist (
    .clk (clk), .rst (rst), .cur (edge_cur), .prev (edge_prev)
  );

  assign cs_fall   = edge_prev[3] & ~cs_s;
  assign sclk_fall = edge_prev[2] & ~sclk_s;
  assign cnv_fall  = edge_prev[1] & ~cnv_s;
  assign busy_rise = ~edge_prev[0] & conv_s;
  assign busy_fall = edge_prev[0] & ~conv_s;

  srp_capture #(.W(DATA_W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .busy_s      (conv_s),
    .busy_rise   (busy_rise),
    .busy_fall   (busy_fall),
    .cnv_fall    (cnv_fall),
    .bit_s       (res_s),
    .stored_q    (stored_word),
    .stored_d    (stored_next),
    .live_have_d (live_have_d),
    .live_bit_d  (live_bit_d)
  );

  srp_shifter #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (cs_fall | busy_fall),
    .load_word (stored_next),
    .adv       (sclk_fall & ~conv_s),
    .head_d    (head_d)
  );

  assign out_bit = live_have_d ? live_bit_d : head_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q   <= ~cs_s;
      dout_q <= ~cs_s & out_bit;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_s,
  input logic         conv_s,
  input logic         cnv_s,
  input logic         sclk_s,
  input logic         res_s,
  input logic [W-1:0] result_q,
  input logic         dout,
  input logic         dout_oe
);
  localparam int CW = $clog2(W + 1);

  logic cs_p, conv_p, cnv_p, sclk_p;
  logic [CW-1:0] falls;
  logic cs_f, conv_f, cnv_f, sclk_f;

  assign cs_f   = cs_p & ~cs_s;
  assign conv_f = conv_p & ~conv_s;
  assign cnv_f  = cnv_p & ~cnv_s;
  assign sclk_f = sclk_p & ~sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= 1'b1; conv_p <= 1'b0; cnv_p <= 1'b0; sclk_p <= 1'b0;
      falls <= '0;
    end else begin
      cs_p <= cs_s; conv_p <= conv_s; cnv_p <= cnv_s; sclk_p <= sclk_s;
      if (cs_f || conv_f)                                   falls <= '0;
      else if (sclk_f && !conv_s && falls != CW'(W))        falls <= falls + 1'b1;
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> !dout); // R2

  AST_MSB_ON_SELECT: assert property (@(posedge clk) disable iff (rst)
    (cs_f && !conv_s && !conv_p) |=> (dout_oe && dout == $past(result_q[W-1]))); // R3

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sclk_f && !cs_s && !cs_p && !conv_s && !conv_p && falls >= CW'(W-1)) |=> !dout); // R5

  AST_LIVE_ECHO: assert property (@(posedge clk) disable iff (rst)
    (cnv_f && conv_s && !cs_s) |=> (dout == $past(res_s))); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !conv_f |=> $stable(result_q)); // R9
endmodule

bind serial_result_port srp_checker #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_s     (cs_s),
  .conv_s   (conv_s),
  .cnv_s    (cnv_s),
  .sclk_s   (sclk_s),
  .res_s    (res_s),
  .result_q (stored_word),
  .dout     (dout),
  .dout_oe  (dout_oe)
);

// File: tb/sim_serial_result_port.sv
module sim_serial_result_port;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, cnv_clk = 1'b0, conv_busy = 1'b0, res_bit = 1'b0;
  logic dout, dout_oe;

  always #2.5 clk = ~clk;

  serial_result_port #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .cnv_clk(cnv_clk),
    .conv_busy(conv_busy), .res_bit(res_bit), .dout(dout), .dout_oe(dout_oe)
  );

  typedef struct {
    logic  oe;
    logic  d;
    string tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  localparam logic [DW-1:0] WORD_A = 16'hA5C3;
  localparam logic [DW-1:0] WORD_B = 16'h3C96;

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(logic oe, logic d, string tag);
    item_t it;
    it.oe = oe; it.d = d; it.tag = tag;
    q.push_back(it);
    ->chk_ev;
  endtask

  task automatic set_cs(logic v);
    cs_n = v;
    idle(6);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1;
    idle(3);
    sclk = 1'b0;
    idle(6);
  endtask

  task automatic cnv_pulse(logic b);
    res_bit = b;
    idle(1);
    cnv_clk = 1'b1;
    idle(3);
    cnv_clk = 1'b0;
    idle(6);
  endtask

  task automatic read_word(logic [DW-1:0] w, int extra, string first_tag);
    expect_out(1'b1, w[DW-1], first_tag);
    for (int k = 1; k < DW; k++) begin
      sclk_pulse();
      expect_out(1'b1, w[DW-1-k], "R4 shift toward LSB");
    end
    for (int k = 0; k < extra; k++) begin
      sclk_pulse();
      expect_out(1'b1, 1'b0, "R5 zeros after LSB");
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (dout_oe !== it.oe || dout !== it.d) begin
          n_bad++;
          $display("FAIL %s: got oe=%b dout=%b, expected oe=%b dout=%b",
                   it.tag, dout_oe, dout, it.oe, it.d);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    expect_out(1'b0, 1'b0, "R1 reset state");

    // R1: read right after reset gives zeros; R2: enable follows select
    set_cs(1'b0);
    expect_out(1'b1, 1'b0, "R1 stored word zero after reset");
    sclk_pulse();
    expect_out(1'b1, 1'b0, "R1 second bit zero");
    set_cs(1'b1);
    expect_out(1'b0, 1'b0, "R2 disabled when deselected");

    // conversion of WORD_A with select high: line stays off (R2), word stored (R9)
    conv_busy = 1'b1;
    idle(6);
    for (int i = 0; i < DW; i++) begin
      cnv_pulse(WORD_A[DW-1-i]);
      if (i == 7) expect_out(1'b0, 1'b0, "R2 off during deselected conversion");
    end
    conv_busy = 1'b0;
    idle(6);
    expect_out(1'b0, 1'b0, "R2 off after conversion");

    // full read with zero tail
    set_cs(1'b0);
    read_word(WORD_A, 3, "R3 MSB before any sclk / R9 stored word");

    // R12: conversion clocks while idle are ignored
    set_cs(1'b1);
    cnv_pulse(1'b0);
    cnv_pulse(1'b0);
    cnv_pulse(1'b1);
    set_cs(1'b0);
    expect_out(1'b1, WORD_A[DW-1], "R6 restart at MSB");
    sclk_pulse();
    expect_out(1'b1, WORD_A[DW-2], "R12 word unchanged by idle clocks");
    sclk_pulse();
    expect_out(1'b1, WORD_A[DW-3], "R12 word unchanged by idle clocks");

    // R6: reselect restarts at MSB
    set_cs(1'b1);
    set_cs(1'b0);
    expect_out(1'b1, WORD_A[DW-1], "R6 restart at MSB after reselect");

    // live conversion of WORD_B with select low
    conv_busy = 1'b1;
    idle(6);
    expect_out(1'b1, WORD_A[DW-1], "R8 old word shown before first bit");
    sclk_pulse();
    expect_out(1'b1, WORD_A[DW-1], "R10 sclk ignored while busy");
    for (int i = 0; i < DW; i++) begin
      cnv_pulse(WORD_B[DW-1-i]);
      expect_out(1'b1, WORD_B[DW-1-i], "R7 live bit");
    end
    conv_busy = 1'b0;
    idle(6);
    expect_out(1'b1, WORD_B[DW-1], "R11 new MSB at end of conversion");
    for (int k = 1; k < DW; k++) begin
      sclk_pulse();
      expect_out(1'b1, WORD_B[DW-1-k], "R9 new stored word");
    end
    sclk_pulse();
    expect_out(1'b1, 1'b0, "R5 zero after LSB");

    set_cs(1'b1);
    expect_out(1'b0, 1'b0, "R2 disabled at end");
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule